// File: doc/BRIEF.md
# Charge-Pump Speedup Timer

This block speeds up channel changes in a fractional-N synthesizer loop. A load strobe marks the write of a new divider word. When speedup is enabled, the strobe opens a timed window. While the window is open, the block selects the high-current setting of the charge pump and can close an open-drain switch that widens the loop filter. When the window closes, both controls go back to steady state without any further action. The length of the window is a 7-bit setting multiplied by a fixed prescale of reference-clock periods. The prescale is 64 by default.

The block runs on the reference clock. A divide-by-2^PRE_W prescaler feeds a down-counter that is loaded from the timer setting. The window closes when the down-counter is spent on a prescaler terminal count. Power-save or a cleared enable closes the window at once. The outputs are gated in the same cycle that either condition appears.

Top module: `cp_speedup_timer`

## Requirements
- R1: With `spd_en_i` low, `cp_fast_o` and `sw_on_o` stay low, and a load strobe starts no window.
- R2: A load strobe sampled at a clock edge, with `spd_en_i` high and `psave_i` low, raises `cp_fast_o` straight after that edge.
- R3: After a strobe with timer value TM (1 to 127), `cp_fast_o` stays high for exactly TM × 2^PRE_W clock cycles and then falls.
- R4: A timer value of 0 gives the same window as a value of 1.
- R5: With `sw_off_i` low, `sw_on_o` equals `cp_fast_o`. With `sw_off_i` high, `sw_on_o` is low.
- R6: A load strobe during an open window restarts the full count using the newly presented timer value.
- R7: While `psave_i` is high, both outputs are low in the same cycle and any open window is cancelled. The outputs stay low after `psave_i` falls until the next strobe.
- R8: A load strobe sampled while `psave_i` is high starts no window.
- R9: While `rst_ni` is low, both outputs are low and no window is open.
- R10: If `spd_en_i` falls during an open window, the outputs drop in the same cycle and the window does not resume when `spd_en_i` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | One-cycle strobe: a new fractional divider word was written |
| spd_en_i | input | 1 | Speedup enable; 0 keeps the pump in low current |
| tm_i | input | TM_W | Window length in prescaler units; 0 is treated as 1 |
| sw_off_i | input | 1 | 1 holds the filter switch off; 0 lets it follow the window |
| psave_i | input | 1 | Section power-save |
| cp_fast_o | output | 1 | High-current select for the charge pump |
| sw_on_o | output | 1 | Turn-on control for the open-drain filter switch |

## Verification
The bench builds the block with PRE_W = 2, so each timer unit lasts four clocks. With this setting, the longest window (TM = 127, 508 cycles) runs next to restarts, power-save cuts and enable drops within a short run. Prescaler phase and down-counter wrap therefore meet every corner. The prescaler and down-counter logic does not depend on PRE_W. The default of 64 changes only how long the counter runs before each terminal count.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_e;
endpackage

// File: rtl/cps_prescaler.sv
module cps_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == PRE_MAX);

  // each unit restarts from phase zero
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o || clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cps_window.sv
module cps_window
  import cps_pkg::*;
#(
  parameter int TM_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic            tick_i,
  input  logic [TM_W-1:0] tm_i,
  output logic            active_o
);
  localparam logic [TM_W-1:0] ONE = TM_W'(1);

  win_state_e      state_q;
  logic [TM_W-1:0] left_q;
  logic [TM_W-1:0] tm_eff;

  assign tm_eff = (tm_i == '0) ? ONE : tm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      left_q  <= '0;
    end else if (abort_i) begin
      state_q <= WIN_IDLE;
      left_q  <= '0;
    end else if (start_i) begin
      state_q <= WIN_RUN;
      left_q  <= tm_eff;
    end else if (state_q == WIN_RUN && tick_i) begin
      if (left_q == ONE) begin
        state_q <= WIN_IDLE;
        left_q  <= '0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign active_o = (state_q == WIN_RUN);

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> (active_o && left_q == (($past(tm_i) == '0) ? ONE : $past(tm_i))));
  p_zero_as_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i && tm_i == '0) |=> (left_q == ONE));
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && tick_i && !start_i && !abort_i && left_q > ONE) |=> (left_q == $past(left_q) - 1'b1));
  p_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !active_o);
endmodule

// File: rtl/cp_speedup_timer.sv
module cp_speedup_timer #(
  parameter int PRE_W = 6,
  parameter int TM_W  = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            spd_en_i,
  input  logic [TM_W-1:0] tm_i,
  input  logic            sw_off_i,
  input  logic            psave_i,
  output logic            cp_fast_o,
  output logic            sw_on_o
);
  logic abort, start, win_active, unit_tick;

  assign abort = !spd_en_i || psave_i;
  assign start = load_i && !abort;

  cps_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start || abort),
    .run_i  (win_active),
    .tick_o (unit_tick)
  );

  cps_window #(.TM_W(TM_W)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .abort_i  (abort),
    .tick_i   (unit_tick),
    .tm_i     (tm_i),
    .active_o (win_active)
  );

  // gate immediately on enable/power-save, no register lag
  assign cp_fast_o = win_active && !abort;
  assign sw_on_o   = cp_fast_o && !sw_off_i;

  p_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spd_en_i |=> !win_active);
  p_psave_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psave_i && load_i) |=> !win_active);
  p_tick_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_tick |-> win_active);
  p_sw_subset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_on_o |-> cp_fast_o);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> win_active);
endmodule

// File: tb/tb_cp_speedup_timer.sv
`timescale 1ns/1ps
module tb_cp_speedup_timer;
  localparam int PRE_W = 2;
  localparam int TM_W  = 7;
  localparam int UNIT  = 1 << PRE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0, en = 1'b0, sw_off = 1'b0, ps = 1'b0;
  logic [TM_W-1:0] tm = '0;
  logic cp_fast, sw_on;

  int checks = 0;
  int errors = 0;
  string phase = "R9";
  int rem = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cp_speedup_timer #(.PRE_W(PRE_W), .TM_W(TM_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .spd_en_i(en), .tm_i(tm),
    .sw_off_i(sw_off), .psave_i(ps), .cp_fast_o(cp_fast), .sw_on_o(sw_on)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // behavioural model: remaining high cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem = 0;
    else if (!en || ps) rem = 0;
    else if (load) rem = ((tm == 0) ? 1 : int'(tm)) * UNIT;
    else if (rem > 0) rem = rem - 1;
  end

  always @(negedge clk) begin
    logic exp_fast;
    exp_fast = (rem > 0) && en && !ps;
    check(cp_fast, exp_fast, phase, "cp_fast_o per-cycle");
    check(sw_on, exp_fast && !sw_off, phase, "sw_on_o per-cycle");
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic strobe(input int t);
    tm = TM_W'(t);
    load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  // measure length of window starting right after a strobe
  task automatic measure(input int t, input int exp_len, input string req);
    int len = 0;
    strobe(t);
    forever begin
      @(negedge clk);
      if (cp_fast) len++;
      else break;
    end
    checks++;
    if (len != exp_len) begin
      errors++;
      $display("FAIL %s window length tm=%0d: got %0d expected %0d", req, t, len, exp_len);
    end
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R9 reset state
    phase = "R9";
    en = 1'b1;
    load = 1'b1;
    tm = 7'd5;
    step(3);
    check(cp_fast, 1'b0, "R9", "cp_fast_o in reset");
    check(sw_on, 1'b0, "R9", "sw_on_o in reset");
    load = 1'b0;
    rst_n = 1'b1;
    step(2);

    // R1 disabled: strobe ignored
    phase = "R1";
    en = 1'b0;
    strobe(10);
    step(20);
    check(cp_fast, 1'b0, "R1", "no window while disabled");
    en = 1'b1;
    step(3);
    check(cp_fast, 1'b0, "R1", "no latent window after enable");

    // R2/R3 basic windows
    phase = "R2";
    strobe(3);
    @(negedge clk);
    check(cp_fast, 1'b1, "R2", "high right after strobe edge");
    #1;
    step(20);
    phase = "R3";
    measure(3, 3 * UNIT, "R3");
    measure(1, UNIT, "R3");
    measure(127, 127 * UNIT, "R3");

    // R4 zero treated as one
    phase = "R4";
    measure(0, UNIT, "R4");

    // R5 switch mode
    phase = "R5";
    sw_off = 1'b1;
    strobe(2);
    @(negedge clk);
    check(sw_on, 1'b0, "R5", "switch held off in window");
    #1;
    sw_off = 1'b0;
    step(1);
    @(negedge clk);
    check(sw_on, 1'b1, "R5", "switch follows window");
    #1;
    step(20);

    // R6 restart during window
    phase = "R6";
    strobe(4);
    step(9);
    measure(2, 2 * UNIT, "R6");
    step(3);

    // R7 power-save cuts window
    phase = "R7";
    strobe(10);
    step(5);
    ps = 1'b1;
    #0.5;
    check(cp_fast, 1'b0, "R7", "cut same cycle by power-save");
    step(3);
    ps = 1'b0;
    step(5);
    check(cp_fast, 1'b0, "R7", "window not resumed after power-save");

    // R8 strobe under power-save
    phase = "R8";
    ps = 1'b1;
    strobe(6);
    ps = 1'b0;
    step(4);
    check(cp_fast, 1'b0, "R8", "strobe ignored in power-save");

    // R10 enable drop mid window
    phase = "R10";
    strobe(8);
    step(6);
    en = 1'b0;
    #0.5;
    check(cp_fast, 1'b0, "R10", "cut same cycle by enable drop");
    step(2);
    en = 1'b1;
    step(4);
    check(cp_fast, 1'b0, "R10", "window not resumed after enable");
    measure(5, 5 * UNIT, "R10");

    step(4);
    finish_run();
  end
endmodule